// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog

This block is a watchdog timer that is controlled through a single 32-bit control register. It also has a read-only status register. Once armed, the watchdog counts down on a slow tick. The tick comes from an internal prescaler that divides the system clock.

If software does not service the watchdog in time, escalation happens in two steps:

- The first expiry raises a non-maskable interrupt line and reloads a short grace count.
- If the grace count also runs out without service, the block emits a one-cycle request for a system reset.

While the stored enable bit is set, a control write is honoured only if it carries a 7-bit key equal to the bitwise complement of the key stored by the last accepted write. A stray or runaway write is therefore very unlikely to feed or disarm the watchdog.

The register port is a plain single-cycle write strobe with a byte address; it has no handshake and no back-pressure. Reads are combinational from the address. Control word layout:

- key in bits [15:9];
- run command in bit 8;
- reload count in bits [7:0];
- the upper half is stored and read back, but has no function.

Top module: `wdg_keyed_top`

## Requirements
- R1: After reset, the control register (byte offset 0x40) and the status register (offset 0x44) both read 0, and `nmi_o` and `rst_req_o` are low.
- R2: While stored bit 8 is 1, a control write whose bits [15:9] differ from the 7-bit complement of the stored key is ignored. The control readback, the NMI level and the timing of the next expiry are all unchanged.
- R3: While stored bit 8 is 0, a control write is accepted whatever its key. An accepted write stores all 32 bits, and they read back at 0x40.
- R4: An accepted write reloads the counter from bits [7:0], with a value of 0 meaning 256 ticks. It also restarts the tick prescaler. With bit 8 set, the first expiry is seen exactly N*TICK_DIV clock cycles after the write edge, where N is the reload.
- R5: An accepted write with bit 8 clear stops the counter. No NMI and no reset request follow, and status bit 1 reads 0.
- R6: The first expiry raises `nmi_o` and sets status bit 0. It reloads GRACE_TICKS and keeps counting, so status reads 3.
- R7: An expiry while the NMI stage is active drives `rst_req_o` high for exactly one cycle, GRACE_TICKS*TICK_DIV cycles after the NMI rose. The counter then stops and `nmi_o` stays high.
- R8: An accepted write lowers `nmi_o` and clears status bit 0 on its own clock edge.
- R9: Status at 0x44 holds the NMI stage in bit 0, the running flag in bit 1, and zeros above. Writes to 0x44 or to any address other than 0x40 change nothing.
- R10: Reads from an unmapped address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Single-cycle write strobe |
| reg_addr | input | ADDR_W | Byte address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| nmi_o | output | 1 | Non-maskable interrupt level, first escalation stage |
| rst_req_o | output | 1 | One-cycle system reset request, second escalation stage |

## Verification
A stored key that has been corrupted shows up on the very next service write. That write is dropped, so the control readback keeps its old value and the NMI arrives on the original schedule instead of the restarted one, within N*TICK_DIV cycles. A counter or prescaler that is off by one moves the NMI or reset edge by whole cycles. The bench measures this against N*TICK_DIV and GRACE_TICKS*TICK_DIV for every reload value from 0 to 10 and for 255. A stage flag stuck high or low appears as a reset request in place of an NMI, or the reverse, at the first expiry, and also in status bits 0 and 1.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned KEY_W    = 7;
  localparam int unsigned RELOAD_W = 8;
  localparam int unsigned ST_STAGE = 0;
  localparam int unsigned ST_RUN   = 1;
  localparam logic [7:0]  OFF_CTRL = 8'h40;
  localparam logic [7:0]  OFF_STAT = 8'h44;

  // control word: key [15:9], run [8], reload [7:0], free upper half
  typedef struct packed {
    logic [15:0]         spare;
    logic [KEY_W-1:0]    key;
    logic                run;
    logic [RELOAD_W-1:0] reload;
  } wdg_ctrl_t;

  function automatic logic [KEY_W-1:0] key_expect(input logic [KEY_W-1:0] prev);
    return ~prev;
  endfunction
endpackage

// File: rtl/wdg_tick_gen.sv
module wdg_tick_gen #(
  parameter int unsigned TICK_DIV = 131579
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  generate
    if (TICK_DIV <= 1) begin : g_passthru
      assign tick = 1'b1;
    end else begin : g_div
      localparam int unsigned PW = $clog2(TICK_DIV);
      localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);
      logic [PW-1:0] pre_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            pre_q <= '0;
        else if (restart)      pre_q <= '0;
        else if (pre_q == LAST) pre_q <= '0;
        else                   pre_q <= pre_q + 1'b1;
      end

      assign tick = (pre_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/wdg_key_gate.sv
module wdg_key_gate
  import wdg_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output wdg_ctrl_t         ctrl_q,
  output logic              accept
);
  wdg_ctrl_t incoming;
  logic      hit;
  logic      key_ok;

  assign incoming = wdg_ctrl_t'(wdata);
  assign hit      = wr && (addr == ADDR_W'(OFF_CTRL));
  assign key_ok   = !ctrl_q.run || (incoming.key == key_expect(ctrl_q.key));
  assign accept   = hit && key_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctrl_q <= '0;
    else if (accept) ctrl_q <= incoming;
  end
endmodule

// File: rtl/wdg_expiry_ctr.sv
module wdg_expiry_ctr
  import wdg_pkg::*;
#(
  parameter int unsigned GRACE_TICKS = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                load,
  input  logic                start,
  input  logic [RELOAD_W-1:0] reload,
  output logic                running,
  output logic                stage,
  output logic                nmi,
  output logic                rst_req
);
  localparam int unsigned LOAD_MAX = 1 << RELOAD_W;
  localparam int unsigned TOP_VAL  = (LOAD_MAX > GRACE_TICKS) ? LOAD_MAX : GRACE_TICKS;
  localparam int unsigned CW       = $clog2(TOP_VAL + 1);

  logic [CW-1:0] ctr_q;
  logic [CW-1:0] load_ticks;
  logic          last_tick;

  assign load_ticks = (reload == '0) ? CW'(LOAD_MAX) : CW'(reload);
  assign last_tick  = running && tick && (ctr_q <= CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctr_q   <= '0;
      running <= 1'b0;
      stage   <= 1'b0;
      nmi     <= 1'b0;
      rst_req <= 1'b0;
    end else if (load) begin
      ctr_q   <= load_ticks;
      running <= start;
      stage   <= 1'b0;
      nmi     <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= 1'b0;
      if (last_tick) begin
        if (!stage) begin
          stage <= 1'b1;
          nmi   <= 1'b1;
          ctr_q <= CW'(GRACE_TICKS);
        end else begin
          rst_req <= 1'b1;
          running <= 1'b0;
          ctr_q   <= '0;
        end
      end else if (running && tick) begin
        ctr_q <= ctr_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdg_keyed_top.sv
module wdg_keyed_top
  import wdg_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned TICK_DIV    = 131579,
  parameter int unsigned GRACE_TICKS = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              nmi_o,
  output logic              rst_req_o
);
  wdg_ctrl_t ctrl_q;
  logic      accept;
  logic      tick;
  logic      running;
  logic      stage;

  wdg_key_gate #(.ADDR_W(ADDR_W)) u_gate (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (reg_wr),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .ctrl_q (ctrl_q),
    .accept (accept)
  );

  wdg_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (accept),
    .tick    (tick)
  );

  wdg_expiry_ctr #(.GRACE_TICKS(GRACE_TICKS)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .load    (accept),
    .start   (reg_wdata[8]),
    .reload  (reg_wdata[RELOAD_W-1:0]),
    .running (running),
    .stage   (stage),
    .nmi     (nmi_o),
    .rst_req (rst_req_o)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(OFF_CTRL)) begin
      reg_rdata = ctrl_q;
    end else if (reg_addr == ADDR_W'(OFF_STAT)) begin
      reg_rdata[ST_STAGE] = stage;
      reg_rdata[ST_RUN]   = running;
    end
  end
endmodule

// File: rtl/wdg_keyed_chk.sv
module wdg_keyed_chk #(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic              nmi_o,
  input logic              rst_req_o,
  input logic              accept,
  input logic [31:0]       ctrl_q,
  input logic              running
);
  // R7
  rst_req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> !rst_req_o);
  // R7
  rst_after_nmi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> nmi_o);
  // R8
  accept_lowers_nmi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !nmi_o);
  // R2
  reject_keeps_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(8'h40) && !accept) |=> $stable(ctrl_q));
  // R3
  accept_stores_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (ctrl_q == $past(reg_wdata)));
  // R5
  stop_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !reg_wdata[8]) |=> !running);
  // R6
  nmi_from_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_o) |-> $past(running));
  // R9
  status_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(8'h44)) |-> (reg_rdata[31:2] == '0));
endmodule

bind wdg_keyed_top wdg_keyed_chk #(.ADDR_W(ADDR_W)) u_wdg_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .nmi_o     (nmi_o),
  .rst_req_o (rst_req_o),
  .accept    (accept),
  .ctrl_q    (ctrl_q),
  .running   (running)
);

// File: tb/test_wdg_keyed_top.sv
`timescale 1ns/1ps
module test_wdg_keyed_top;
  localparam int DIV = 4;
  localparam int GR  = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        nmi_o;
  logic        rst_req_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int wcyc = 0;
  bit done = 1'b0;
  logic [6:0] key_q = '0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdg_keyed_top #(.ADDR_W(8), .TICK_DIV(DIV), .GRACE_TICKS(GR)) i_wdg_keyed_top (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .nmi_o(nmi_o), .rst_req_o(rst_req_o)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [6:0] k, input bit en, input logic [7:0] n);
    return {8'hA5, n ^ 8'h3C, k, en, n};
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    wcyc = cyc;
    reg_wr = 1'b0; reg_addr = 8'h00;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_nmi(input int from, output int lat);
    while (nmi_o !== 1'b1 && (cyc - from) < 5000) begin @(posedge clk); #1; end
    lat = cyc - from;
  endtask

  task automatic wait_rst(input int from, output int lat);
    while (rst_req_o !== 1'b1 && (cyc - from) < 5000) begin @(posedge clk); #1; end
    lat = cyc - from;
  endtask

  function automatic int ticks_of(input int n);
    return (n == 0) ? 256 : n;
  endfunction

  // serve with correct key, run, measure both expiry stages
  task automatic run_expiry(input int n);
    logic [31:0] v, d;
    int lat, w0, ncyc;
    v = mk(~key_q, 1'b1, 8'(n));
    wr(8'h40, v); w0 = wcyc; key_q = ~key_q;
    chk("R8 nmi low after service", nmi_o, 0);
    rd(8'h40, d); chk("R3 ctrl readback", d, v);
    rd(8'h44, d); chk("R9 status running", d, 2);
    wait_nmi(w0, lat); ncyc = cyc;
    chk("R4 first expiry latency", lat, DIV * ticks_of(n));
    rd(8'h44, d); chk("R6 status nmi stage", d, 3);
    wait_rst(ncyc, lat);
    chk("R7 reset request latency", lat, DIV * GR);
    @(posedge clk); #1;
    chk("R7 reset request one cycle", rst_req_o, 0);
    chk("R7 nmi held", nmi_o, 1);
    rd(8'h44, d); chk("R7 stopped after reset request", d, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, v, hold;
    int lat, w0;
    bit seen;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1
    rd(8'h40, d); chk("R1 ctrl reset", d, 0);
    rd(8'h44, d); chk("R1 status reset", d, 0);
    chk("R1 nmi reset", nmi_o, 0);
    chk("R1 rst_req reset", rst_req_o, 0);
    // R10
    rd(8'h00, d); chk("R10 unmapped read", d, 0);
    rd(8'h48, d); chk("R10 unmapped read", d, 0);

    key_q = 7'h6A;  // first write: enable clear, so ~key_q is accepted like any key
    for (int n = 1; n <= 10; n++) run_expiry(n);
    run_expiry(0);
    run_expiry(255);

    // R2: wrong keys ignored, timing not restarted
    v = mk(~key_q, 1'b1, 8'd5);
    wr(8'h40, v); w0 = wcyc; key_q = ~key_q; hold = v;
    repeat (DIV) @(posedge clk);
    wr(8'h40, mk(key_q, 1'b1, 8'd60));
    rd(8'h40, d); chk("R2 ctrl kept on bad key", d, hold);
    wait_nmi(w0, lat); chk("R2 expiry not restarted", lat, DIV * 5);
    wr(8'h40, mk(~key_q ^ 7'h01, 1'b1, 8'd60));
    chk("R2 nmi kept on bad key", nmi_o, 1);
    rd(8'h40, d); chk("R2 ctrl kept after nmi", d, hold);

    // R5: accepted stop
    v = mk(~key_q, 1'b0, 8'd1);
    wr(8'h40, v); w0 = wcyc; key_q = ~key_q;
    seen = 1'b0;
    repeat (DIV * (1 + GR + 4)) begin
      @(posedge clk); #1;
      if (nmi_o || rst_req_o) seen = 1'b1;
    end
    chk("R5 no escalation when stopped", seen, 0);
    rd(8'h44, d); chk("R5 status stopped", d, 0);

    // R3: enable clear, arbitrary key accepted
    v = mk(key_q ^ 7'h55, 1'b1, 8'd6);
    wr(8'h40, v); w0 = wcyc; key_q = key_q ^ 7'h55;
    rd(8'h40, d); chk("R3 any key while disabled", d, v);
    // R9: writes elsewhere ignored
    wr(8'h44, 32'hFFFF_FFFF);
    wr(8'h48, mk(~key_q, 1'b0, 8'd1));
    rd(8'h40, d); chk("R9 ctrl untouched by other addresses", d, v);
    rd(8'h44, d); chk("R9 status untouched by write", d, 2);
    wait_nmi(w0, lat); chk("R9 timing untouched by other addresses", lat, DIV * 6);
    wait_rst(cyc, lat); chk("R7 reset after grace", lat, DIV * GR);

    // R4: mid-count service restarts the count and the prescaler phase
    v = mk(~key_q, 1'b1, 8'd4);
    wr(8'h40, v); key_q = ~key_q;
    repeat (DIV * 2 + 1) @(posedge clk);
    wr(8'h40, mk(~key_q, 1'b1, 8'd4)); w0 = wcyc; key_q = ~key_q;
    wait_nmi(w0, lat); chk("R4 restarted count latency", lat, DIV * 4);
    // R8
    wr(8'h40, mk(~key_q, 1'b1, 8'd9)); key_q = ~key_q;
    chk("R8 service lowers nmi", nmi_o, 0);
    rd(8'h44, d); chk("R8 stage cleared", d, 2);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule